// File: doc/BRIEF.md
# Speculative Fault Deferral Tracker

This block keeps one taint bit for every architectural register and decides, for each issued instruction, whether that instruction must fault now, report an exception now, or quietly mark its result as tainted. An instruction hoisted above a branch may hit a terminating exception, such as a protection violation. That exception stays silent: the taint is recorded on the destination register and travels through later speculative consumers. It becomes a fault only when a non-speculative instruction reads a tainted register. Exceptions that a handler can repair and resume from, such as page faults, are never deferred.

Instructions arrive one per beat on a valid/ready issue interface. The unit accepts a beat when `iss_valid` and `iss_ready` are both high. `iss_ready` goes low only in a cycle where a taint-vector restore is requested, so the issuing stage holds its beat for that one cycle. The verdict of an accepted beat appears on the registered outputs in the next cycle. Any taint change is visible on the save port from that same cycle, so the next beat already sees it. The whole taint vector is always readable on a save port. It can be written in a single cycle through a restore port, which supports a context switch.

Top module: `poison_defer_unit`

## Requirements
- R1: After reset every taint bit is 0 (save port reads all zeros) and `flt_valid` and `exc_valid` are 0.
- R2: An accepted speculative beat with `iss_wr`=1 and `iss_exc_term`=1 and no non-terminating exception sets the taint of `iss_dst` and produces neither `flt_valid` nor `exc_valid`.
- R3: An accepted beat with `iss_exc_soft`=1 and no deferred fault raises `exc_valid` in the next cycle, whether or not it is speculative, and changes no taint bit.
- R4: An accepted speculative beat that writes and reads a tainted enabled source sets the taint of `iss_dst` and does not fault.
- R5: An accepted non-speculative beat that reads a tainted enabled source raises `flt_valid` in the next cycle. `flt_reg` then holds source A's index if A is tainted, otherwise B's index. No taint bit changes.
- R6: A beat with `iss_store`=1 is treated as non-speculative whatever `iss_spec` says. It faults on a tainted address or data source and never changes a taint bit.
- R7: An accepted speculative beat that writes, raises no exception and reads no tainted source clears the taint of `iss_dst`.
- R8: An accepted non-speculative non-store beat that writes without any exception clears the taint of `iss_dst`. With `iss_exc_term`=1 and no fault, it raises `exc_valid` in the next cycle and leaves the taint unchanged.
- R9: Register 0 is never tainted: bit 0 of the save port is always 0, even after a restore with bit 0 set.
- R10: Bit i of `ctx_save_vec` is the taint of register i at all times. When `ctx_restore_en` is high, `iss_ready` is low, the vector is loaded from `ctx_restore_vec` at the clock edge, and both verdict outputs are 0 in the next cycle.
- R11: A source whose use flag is low is ignored for faults and taint propagation, even if its index names a tainted register.
- R12: Deferred faults take priority over exceptions: a non-speculative beat reading a tainted source raises only `flt_valid`, even when it also reports an exception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Issue beat present |
| iss_ready | output | 1 | Unit accepts the beat (low during restore) |
| iss_spec | input | 1 | Beat is speculative |
| iss_store | input | 1 | Beat is a store |
| iss_wr | input | 1 | Beat writes `iss_dst` |
| iss_exc_term | input | 1 | Execution raised a terminating exception |
| iss_exc_soft | input | 1 | Execution raised a resumable exception |
| iss_use_a | input | 1 | Source A is read |
| iss_src_a | input | 5 | Source A register index |
| iss_use_b | input | 1 | Source B is read |
| iss_src_b | input | 5 | Source B register index |
| iss_dst | input | 5 | Destination register index |
| flt_valid | output | 1 | Deferred fault for the previous accepted beat |
| flt_reg | output | 5 | First tainted source that caused the fault |
| exc_valid | output | 1 | Immediate exception for the previous accepted beat |
| ctx_save_vec | output | 32 | Current taint vector |
| ctx_restore_en | input | 1 | Load the taint vector this cycle |
| ctx_restore_vec | input | 32 | Vector to load |

## Verification
The hardest situation to reach is a taint carried through a chain: a speculative exception taints a register, speculative consumers pass it on, and only a later non-speculative read turns it into a fault, with the right source reported when both sources are tainted. Random stimulus draws register indices from a small window, so tainted registers are read again often. A directed sequence builds a three-step chain, then checks the source priority, the store case, and a restore that arrives while a beat is waiting. A model in the bench tracks the taint vector and predicts each verdict.

// File: rtl/pb_pkg.sv
package pb_pkg;
  // action applied to the destination taint bit
  typedef enum logic [1:0] {
    DST_KEEP   = 2'd0,
    DST_TAINT  = 2'd1,
    DST_CLEAN  = 2'd2
  } dst_act_e;

  typedef struct packed {
    logic     flt;
    logic     exc;
    dst_act_e act;
  } pb_verdict_t;
endpackage

// File: rtl/pb_src_check.sv
module pb_src_check #(
  parameter int NREG = 32,
  parameter int NSRC = 2,
  localparam int AW = $clog2(NREG)
) (
  input  logic [NREG-1:0]          taint_vec,
  input  logic [NSRC-1:0][AW-1:0]  src_idx,
  input  logic [NSRC-1:0]          src_use,
  output logic                     any_hit,
  output logic [AW-1:0]            first_idx
);
  logic [NSRC-1:0] hit;

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    assign hit[s] = src_use[s] & taint_vec[src_idx[s]];
  end

  assign any_hit = |hit;

  // lowest-numbered tainted source wins
  always_comb begin
    first_idx = '0;
    for (int s = NSRC - 1; s >= 0; s--) begin
      if (hit[s]) first_idx = src_idx[s];
    end
  end
endmodule

// File: rtl/pb_decide.sv
module pb_decide
  import pb_pkg::*;
(
  input  logic        spec,
  input  logic        store,
  input  logic        wr,
  input  logic        exc_term,
  input  logic        exc_soft,
  input  logic        any_hit,
  output pb_verdict_t verdict
);
  logic nonspec;
  assign nonspec = ~spec | store;

  always_comb begin
    verdict = '{flt: 1'b0, exc: 1'b0, act: DST_KEEP};
    if (nonspec && any_hit) begin
      verdict.flt = 1'b1;
    end else if (exc_soft) begin
      verdict.exc = 1'b1;
    end else if (nonspec) begin
      if (exc_term)          verdict.exc = 1'b1;
      else if (wr && !store) verdict.act = DST_CLEAN;
    end else if (wr) begin
      verdict.act = (exc_term || any_hit) ? DST_TAINT : DST_CLEAN;
    end
  end
endmodule

// File: rtl/pb_regfile.sv
module pb_regfile #(
  parameter int NREG = 32,
  localparam int AW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            restore_en,
  input  logic [NREG-1:0] restore_vec,
  input  logic            upd_en,
  input  logic [AW-1:0]   upd_idx,
  input  logic            upd_val,
  output logic [NREG-1:0] taint_vec
);
  assign taint_vec[0] = 1'b0;

  for (genvar i = 1; i < NREG; i++) begin : g_bit
    logic bit_q;
    always_ff @(posedge clk) begin
      if (!rst_n)                                   bit_q <= 1'b0;
      else if (restore_en)                          bit_q <= restore_vec[i];
      else if (upd_en && upd_idx == AW'(i))         bit_q <= upd_val;
    end
    assign taint_vec[i] = bit_q;
  end
endmodule

// File: rtl/poison_defer_unit.sv
module poison_defer_unit
  import pb_pkg::*;
#(
  parameter int NREG = 32,
  localparam int AW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            iss_valid,
  output logic            iss_ready,
  input  logic            iss_spec,
  input  logic            iss_store,
  input  logic            iss_wr,
  input  logic            iss_exc_term,
  input  logic            iss_exc_soft,
  input  logic            iss_use_a,
  input  logic [AW-1:0]   iss_src_a,
  input  logic            iss_use_b,
  input  logic [AW-1:0]   iss_src_b,
  input  logic [AW-1:0]   iss_dst,
  output logic            flt_valid,
  output logic [AW-1:0]   flt_reg,
  output logic            exc_valid,
  output logic [NREG-1:0] ctx_save_vec,
  input  logic            ctx_restore_en,
  input  logic [NREG-1:0] ctx_restore_vec
);
  logic             accept;
  logic             any_hit;
  logic [AW-1:0]    first_idx;
  pb_verdict_t      verdict;
  logic [NREG-1:0]  taint_vec;

  assign iss_ready = ~ctx_restore_en;
  assign accept    = iss_valid & iss_ready;

  pb_src_check #(.NREG(NREG), .NSRC(2)) u_src (
    .taint_vec (taint_vec),
    .src_idx   ({iss_src_b, iss_src_a}),
    .src_use   ({iss_use_b, iss_use_a}),
    .any_hit   (any_hit),
    .first_idx (first_idx)
  );

  pb_decide u_dec (
    .spec     (iss_spec),
    .store    (iss_store),
    .wr       (iss_wr),
    .exc_term (iss_exc_term),
    .exc_soft (iss_exc_soft),
    .any_hit  (any_hit),
    .verdict  (verdict)
  );

  pb_regfile #(.NREG(NREG)) u_rf (
    .clk         (clk),
    .rst_n       (rst_n),
    .restore_en  (ctx_restore_en),
    .restore_vec (ctx_restore_vec),
    .upd_en      (accept && verdict.act != DST_KEEP),
    .upd_idx     (iss_dst),
    .upd_val     (verdict.act == DST_TAINT),
    .taint_vec   (taint_vec)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flt_valid <= 1'b0;
      exc_valid <= 1'b0;
      flt_reg   <= '0;
    end else begin
      flt_valid <= accept & verdict.flt;
      exc_valid <= accept & verdict.exc;
      if (accept && verdict.flt) flt_reg <= first_idx;
    end
  end

  assign ctx_save_vec = taint_vec;
endmodule

// File: rtl/pb_chk.sv
module pb_chk #(
  parameter int NREG = 32,
  localparam int AW = $clog2(NREG)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            iss_valid,
  input logic            iss_ready,
  input logic            iss_spec,
  input logic            iss_store,
  input logic            iss_wr,
  input logic            iss_exc_term,
  input logic            iss_exc_soft,
  input logic [AW-1:0]   iss_dst,
  input logic            flt_valid,
  input logic            exc_valid,
  input logic [NREG-1:0] ctx_save_vec,
  input logic            ctx_restore_en,
  input logic [NREG-1:0] ctx_restore_vec
);
  // R9
  zero_reg_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctx_save_vec[0]);

  // R5
  flt_needs_nonspec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flt_valid |-> $past(iss_valid && iss_ready && (!iss_spec || iss_store)));

  // R12
  flt_exc_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(flt_valid && exc_valid));

  // R2
  spec_term_taints_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_ready && iss_spec && !iss_store && iss_wr && iss_exc_term
     && !iss_exc_soft && iss_dst != '0)
    |=> (ctx_save_vec[$past(iss_dst)] && !flt_valid && !exc_valid));

  // R10
  restore_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctx_restore_en |=> (ctx_save_vec[NREG-1:1] == $past(ctx_restore_vec[NREG-1:1])
                        && !flt_valid && !exc_valid));

  // R6
  store_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_ready && iss_store) |=> $stable(ctx_save_vec));

  // R3
  vec_change_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctx_save_vec) |-> $past(ctx_restore_en || (iss_valid && iss_wr && !iss_exc_soft)));
endmodule

bind poison_defer_unit pb_chk #(.NREG(NREG)) u_pb_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .iss_valid       (iss_valid),
  .iss_ready       (iss_ready),
  .iss_spec        (iss_spec),
  .iss_store       (iss_store),
  .iss_wr          (iss_wr),
  .iss_exc_term    (iss_exc_term),
  .iss_exc_soft    (iss_exc_soft),
  .iss_dst         (iss_dst),
  .flt_valid       (flt_valid),
  .exc_valid       (exc_valid),
  .ctx_save_vec    (ctx_save_vec),
  .ctx_restore_en  (ctx_restore_en),
  .ctx_restore_vec (ctx_restore_vec)
);

// File: tb/tb_poison_defer_unit.sv
module tb_poison_defer_unit;
  localparam int NREG = 32;
  localparam int AW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic iss_valid = 0, iss_spec = 0, iss_store = 0, iss_wr = 0;
  logic iss_exc_term = 0, iss_exc_soft = 0, iss_use_a = 0, iss_use_b = 0;
  logic [AW-1:0] iss_src_a = '0, iss_src_b = '0, iss_dst = '0;
  logic iss_ready, flt_valid, exc_valid;
  logic [AW-1:0] flt_reg;
  logic [NREG-1:0] ctx_save_vec;
  logic ctx_restore_en = 0;
  logic [NREG-1:0] ctx_restore_vec = '0;

  int total = 0;
  int bad = 0;
  logic [NREG-1:0] model = '0;

  always #10 clk = ~clk;

  poison_defer_unit #(.NREG(NREG)) dut (.*);

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected verdict from the requirements
  function automatic logic [6:0] predict(logic sp, logic st, logic w, logic te, logic ts,
                                          logic ua, logic [AW-1:0] a, logic ub,
                                          logic [AW-1:0] b);
    logic ha, hb, ns, f, e;
    logic [AW-1:0] fr;
    ha = ua & model[a];
    hb = ub & model[b];
    ns = ~sp | st;
    f = 0; e = 0; fr = '0;
    if (ns && (ha || hb)) begin f = 1; fr = ha ? a : b; end
    else if (ts) e = 1;
    else if (ns && te) e = 1;
    return {f, e, fr};
  endfunction

  task automatic op(string req, logic sp, logic st, logic w, logic te, logic ts,
                    logic ua, logic [AW-1:0] a, logic ub, logic [AW-1:0] b,
                    logic [AW-1:0] d);
    logic [6:0] v;
    logic ns, hit;
    iss_valid = 1; iss_spec = sp; iss_store = st; iss_wr = w;
    iss_exc_term = te; iss_exc_soft = ts; iss_use_a = ua; iss_src_a = a;
    iss_use_b = ub; iss_src_b = b; iss_dst = d;
    v = predict(sp, st, w, te, ts, ua, a, ub, b);
    ns = ~sp | st;
    hit = (ua & model[a]) | (ub & model[b]);
    if (!v[6] && !ts && w && !st && d != 0) begin
      if (!ns) model[d] = te | hit;
      else if (!te) model[d] = 1'b0;
    end
    @(negedge clk);
    iss_valid = 0;
    chk({req, " flt"}, 64'(flt_valid), 64'(v[6]));
    chk({req, " exc"}, 64'(exc_valid), 64'(v[5]));
    if (v[6]) chk({req, " flt_reg"}, 64'(flt_reg), 64'(v[4:0]));
    chk({req, " vec"}, 64'(ctx_save_vec), 64'(model));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 vec", 64'(ctx_save_vec), 64'd0);
    chk("R1 flt", 64'(flt_valid), 64'd0);
    chk("R1 exc", 64'(exc_valid), 64'd0);

    // chain: spec fault taints r5, spec consumer propagates to r6, nonspec read faults
    op("R2", 1,0,1,1,0, 0,0, 0,0, 5);
    op("R4", 1,0,1,0,0, 1,5, 0,0, 6);
    op("R11", 0,0,1,0,0, 0,6, 1,1, 7);
    op("R5", 0,0,1,0,0, 1,3, 1,6, 8);
    op("R5 both", 0,0,1,0,0, 1,5, 1,6, 9);
    op("R12", 0,0,1,1,1, 1,2, 1,5, 10);
    op("R6 store", 1,1,0,0,0, 1,1, 1,6, 0);
    op("R6 clean", 1,1,1,0,0, 1,1, 1,2, 5);
    op("R3 spec", 1,0,1,0,1, 0,0, 0,0, 11);
    op("R3 nonspec", 0,0,1,0,1, 0,0, 0,0, 5);
    op("R7", 1,0,1,0,0, 1,1, 0,0, 6);
    op("R8 term", 0,0,1,1,0, 1,1, 0,0, 5);
    op("R8 clean", 0,0,1,0,0, 1,1, 0,0, 5);
    op("R9", 1,0,1,1,0, 0,0, 0,0, 0);

    // restore with a beat waiting
    iss_valid = 1; iss_spec = 1; iss_wr = 1; iss_exc_term = 1; iss_dst = 20;
    iss_use_a = 0; iss_use_b = 0; iss_store = 0; iss_exc_soft = 0;
    ctx_restore_en = 1; ctx_restore_vec = 32'h8000_0013;
    #1 chk("R10 ready", 64'(iss_ready), 64'd0);
    @(negedge clk);
    ctx_restore_en = 0; iss_valid = 0;
    model = 32'h8000_0012;
    chk("R10 vec", 64'(ctx_save_vec), 64'(model));
    chk("R10 flt", 64'(flt_valid), 64'd0);
    chk("R10 exc", 64'(exc_valid), 64'd0);
    op("R10 use", 0,0,1,0,0, 1,31, 0,0, 2);

    for (int n = 0; n < 800; n++) begin
      logic [AW-1:0] ra, rb, rd;
      ra = AW'($urandom_range(0, 7));
      rb = AW'($urandom_range(0, 7));
      rd = AW'($urandom_range(0, 7));
      op("R4/R5 rnd", ($urandom_range(0, 2) != 0), ($urandom_range(0, 7) == 0),
         ($urandom_range(0, 5) != 0), ($urandom_range(0, 3) == 0),
         ($urandom_range(0, 9) == 0), ($urandom_range(0, 3) != 0), ra,
         ($urandom_range(0, 1) == 1), rb, rd);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule